// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches one active-low interrupt pin and turns its activity into a pending request for the processor. The pin is first passed through a synchroniser. A falling edge on the synchronised pin sets an internal pending latch. A mode bit can also let a low level keep setting the latch. While the pending latch is set, an interrupt request goes to the CPU unless a mask bit blocks it.

Software reaches the block through one 8-bit control/status register on a simple peripheral bus. The bus has a select, an address, a write strobe and write data, and read data comes back one cycle after the access. Writing a 1 to the acknowledge bit clears the pending latch. Debug logic can hold the block in a halt state. During a halt, an acknowledge has no effect on the latch unless a separate clear-enable input is high. This stops a debugger's register accesses from losing an interrupt.

Top module: `extint_ctrl`

## Requirements
- R1: A falling edge on `pin_n` sets the pending latch within three clock edges of the pin change. The latch is visible as register bit 3.
- R2: Register layout: bit 0 is the level-mode bit, bit 1 is the mask bit, bit 2 is the acknowledge bit, which always reads 0, bit 3 is the pending flag, and bits 7:4 read 0. Read data appears on `bus_rdata` on the edge that samples the read access.
- R3: With the level-mode bit at 0, a pin that stays low after its falling edge does not set the latch again once it has been acknowledged.
- R4: `cpu_irq` is 1 exactly when the pending latch is set and the mask bit is 0.
- R5: The pending flag reads 1 whenever the latch is set, whatever the state of the mask bit.
- R6: After reset the register reads 0x00 and `cpu_irq` is 0.
- R7: With the level-mode bit at 1, an acknowledge while the synchronised pin is low leaves the latch set. An acknowledge after the pin has returned high clears it.
- R8: While `halt_active` is 1 and `halt_clr_en` is 0, writing 1 to bit 2 leaves the latch set. With `halt_clr_en` at 1, the same write clears the latch.
- R9: A write whose address differs from `REG_ADDR` has no effect. Writing to bits 7:3 has no effect.
- R10: If a falling edge and an acknowledge write reach the latch on the same edge, the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| bus_sel | input | 1 | Peripheral bus select |
| bus_wr | input | 1 | Write strobe, 0 for a read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, 0 when not read |
| halt_active | input | 1 | System is in a debug halt |
| halt_clr_en | input | 1 | Lets an acknowledge clear the latch during a halt |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
Two functions can act on the pending latch in the same cycle: a new pin edge that sets it and an acknowledge write that clears it. To provoke this, the bench times the pin's falling edge so that the edge leaves the synchroniser on exactly the edge that takes the acknowledge write. It then reads the register, and the result passes only if the pending bit is still set and `cpu_irq` is high. The level-mode case, where an acknowledge arrives while the pin is still low, is judged the same way.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_MODE = 0;
  localparam int BIT_MASK = 1;
  localparam int BIT_ACK  = 2;
  localparam int BIT_PEND = 3;

  typedef struct packed {
    logic mask;
    logic level;
  } ctl_t;

  function automatic logic [REG_W-1:0] pack_status(input ctl_t c, input logic pend);
    logic [REG_W-1:0] v;
    v           = '0;
    v[BIT_MODE] = c.level;
    v[BIT_MASK] = c.mask;
    v[BIT_PEND] = pend;
    return v;
  endfunction
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic pin_s
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= pin_n;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], pin_n};
      end
    end
  endgenerate

  assign pin_s = chain[STAGES-1];
endmodule

// File: rtl/extint_trigger.sv
module extint_trigger (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic level_mode,
  output logic pin_prev,
  output logic fall,
  output logic set_req
);
  always_ff @(posedge clk) begin
    if (rst) pin_prev <= 1'b1;
    else     pin_prev <= pin_s;
  end

  always_comb begin
    fall    = pin_prev & ~pin_s;
    set_req = fall | (level_mode & ~pin_s);
  end
endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              halt_active,
  input  logic              halt_clr_en,
  input  logic              pend,
  output ctl_t              ctl,
  output ctl_t              ctl_nxt,
  output logic              ack_hit,
  output logic [REG_W-1:0]  rdata
);
  logic hit, wr_hit, rd_hit, clr_allowed;
  logic unused_wbits;

  assign unused_wbits = &{1'b0, bus_wdata[REG_W-1:BIT_PEND]};

  always_comb begin
    hit         = bus_sel && (bus_addr == REG_ADDR);
    wr_hit      = hit && bus_wr;
    rd_hit      = hit && !bus_wr;
    clr_allowed = !halt_active || halt_clr_en;
    ack_hit     = wr_hit && bus_wdata[BIT_ACK] && clr_allowed;
    ctl_nxt     = ctl;
    if (wr_hit) begin
      ctl_nxt.level = bus_wdata[BIT_MODE];
      ctl_nxt.mask  = bus_wdata[BIT_MASK];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl   <= '0;
      rdata <= '0;
    end else begin
      ctl   <= ctl_nxt;
      rdata <= rd_hit ? pack_status(ctl, pend) : '0;
    end
  end
endmodule

// File: rtl/extint_latch.sv
module extint_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  output logic pend,
  output logic pend_nxt
);
  always_comb begin
    if (set_req)      pend_nxt = 1'b1;
    else if (clr_req) pend_nxt = 1'b0;
    else              pend_nxt = pend;
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= pend_nxt;
  end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 4'h5,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              halt_active,
  input  logic              halt_clr_en,
  output logic              cpu_irq
);
  logic pin_s, pin_prev, fall, set_req;
  logic ack_hit, pend_q, pend_nxt;
  ctl_t ctl, ctl_nxt;

  extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_n(pin_n), .pin_s(pin_s)
  );

  extint_trigger u_trig (
    .clk(clk), .rst(rst), .pin_s(pin_s), .level_mode(ctl.level),
    .pin_prev(pin_prev), .fall(fall), .set_req(set_req)
  );

  extint_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .halt_active(halt_active), .halt_clr_en(halt_clr_en),
    .pend(pend_q), .ctl(ctl), .ctl_nxt(ctl_nxt),
    .ack_hit(ack_hit), .rdata(bus_rdata)
  );

  extint_latch u_latch (
    .clk(clk), .rst(rst), .set_req(set_req), .clr_req(ack_hit),
    .pend(pend_q), .pend_nxt(pend_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) cpu_irq <= 1'b0;
    else     cpu_irq <= pend_nxt & ~ctl_nxt.mask;
  end
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       pin_s,
  input logic       pin_prev,
  input logic       pend,
  input logic       mask,
  input logic       level,
  input logic       ack_hit,
  input logic       halt_active,
  input logic       halt_clr_en,
  input logic       cpu_irq,
  input logic [7:0] rdata
);
  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
    (pin_prev && !pin_s) |=> pend); // R1
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdata[7:4] == 4'h0) && !rdata[2]); // R2
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == (pend && !mask)); // R4
  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (rdata == 8'h00) && !cpu_irq && !pend); // R6
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (level && !pin_s) |=> pend); // R7
  AST_HALT_GUARD: assert property (@(posedge clk) disable iff (rst)
    (halt_active && !halt_clr_en && pend) |=> pend); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (pin_prev && !pin_s && ack_hit) |=> pend); // R10
endmodule

bind extint_ctrl extint_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .pin_s(pin_s), .pin_prev(pin_prev),
  .pend(pend_q), .mask(ctl.mask), .level(ctl.level), .ack_hit(ack_hit),
  .halt_active(halt_active), .halt_clr_en(halt_clr_en),
  .cpu_irq(cpu_irq), .rdata(bus_rdata)
);

// File: tb/extint_ctrl_test.sv
`timescale 1ns/1ps
module extint_ctrl_test;
  localparam logic [3:0] RA = 4'h5;

  logic clk = 1'b0, rst = 1'b1, pin_n = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic halt_active = 1'b0, halt_clr_en = 1'b0, cpu_irq;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic rd_fire = 1'b0;

  always #5 clk = ~clk;

  extint_ctrl uut (
    .clk(clk), .rst(rst), .pin_n(pin_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .halt_active(halt_active), .halt_clr_en(halt_clr_en), .cpu_irq(cpu_irq)
  );

  always @(posedge clk) rd_fire <= !rst && bus_sel && !bus_wr && (bus_addr == RA);

  always @(negedge clk) begin
    if (rd_fire && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual %02h expected %02h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] e, input string t);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = RA;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (cpu_irq !== e) begin
      errors++;
      $display("FAIL %s: cpu_irq actual %0b expected %0b", t, cpu_irq, e);
    end
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk);
    pin_n = v;
    wait_cyc(4);
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    @(negedge clk) rst = 1'b0;
    chk_irq(1'b0, "R6 reset irq");
    rd(8'h00, "R6 reset value");

    // edge mode, unmasked
    set_pin(1'b0);
    chk_irq(1'b1, "R4 irq on pending");
    rd(8'h08, "R1 edge sets pending");
    wr(RA, 8'h04);
    wait_cyc(3);
    rd(8'h00, "R3 held low no retrigger");
    chk_irq(1'b0, "R3 irq after ack");
    set_pin(1'b1);

    // masked
    wr(RA, 8'h02);
    set_pin(1'b0);
    rd(8'h0A, "R5 pending visible while masked");
    chk_irq(1'b0, "R4 masked irq");
    wr(RA, 8'h00);
    chk_irq(1'b1, "R4 unmask irq");
    wr(RA, 8'h04);
    rd(8'h00, "R2 ack reads zero");
    set_pin(1'b1);

    // level mode
    wr(RA, 8'h01);
    rd(8'h01, "R2 mode bit 0");
    set_pin(1'b0);
    rd(8'h09, "R7 level pending");
    wr(RA, 8'h05);
    wait_cyc(2);
    rd(8'h09, "R7 ack while low");
    chk_irq(1'b1, "R7 irq while low");
    set_pin(1'b1);
    rd(8'h09, "R7 stays latched after release");
    wr(RA, 8'h05);
    rd(8'h01, "R7 ack after release");
    chk_irq(1'b0, "R7 irq cleared");
    wr(RA, 8'h00);

    // halt protection
    halt_active = 1'b1; halt_clr_en = 1'b0;
    set_pin(1'b0);
    wr(RA, 8'h04);
    rd(8'h08, "R8 ack blocked in halt");
    halt_clr_en = 1'b1;
    wr(RA, 8'h04);
    rd(8'h00, "R8 ack enabled in halt");
    halt_active = 1'b0; halt_clr_en = 1'b0;
    set_pin(1'b1);

    // address and ignored bits
    set_pin(1'b0);
    wr(RA ^ 4'h1, 8'h07);
    rd(8'h08, "R9 other address ignored");
    wr(RA, 8'hF8);
    rd(8'h08, "R9 upper bits ignored");
    wr(RA, 8'h04);
    rd(8'h00, "R9 ack clears");
    set_pin(1'b1);

    // edge and ack on the same latch edge
    @(negedge clk) pin_n = 1'b0;
    @(negedge clk);
    wr(RA, 8'h04);
    rd(8'h08, "R10 set beats ack");
    chk_irq(1'b1, "R10 irq kept");
    wr(RA, 8'h04);
    rd(8'h00, "R10 later ack clears");
    set_pin(1'b1);

    wait_cyc(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule